// File: doc/BRIEF.md
# Keyboard Receive Port with Memory-Mapped Registers

This block is a bus-slave peripheral that gives a processor one keyboard input channel through two memory-mapped registers. The keyboard side delivers a one-cycle strobe carrying an 8-bit character. The port holds that character in a data register and raises a ready flag in a control register. Software can poll the flag, or it can set an interrupt-enable bit so that an interrupt request goes to the processor's interrupt controller while a character is waiting.

The block also contains the address decode for the I/O region. Any bus access at address 0xFFFF0000 or above is steered to device registers, and every access below that is steered to main memory. A load of the data register has a side effect: it returns the character and clears the ready flag, which also drops the interrupt request. Only one character is held. A newer key replaces an unread one.

Top module: `kbd_mmio_port`

## Requirements
- R1: While bus_req_i is high, an address of 0xFFFF0000 or above drives dev_sel_o=1 and mem_sel_o=0. Any lower address drives mem_sel_o=1 and dev_sel_o=0. Both outputs are combinational and are 0 while bus_req_i is low.
- R2: The control register sits at 0xFFFF0000 and the data register at 0xFFFF0004. Any other I/O address reads as zero, and stores to it change nothing.
- R3: A cycle with key_valid_i=1 sets ready (control bit 0) and stores key_char_i in data bits 7:0, with bits 31:8 reading zero. The new state is visible after that rising edge.
- R4: A load of the data register returns the stored character in the same cycle and clears ready at the next rising edge.
- R5: The data register is read-only. A store to 0xFFFF0004 leaves the stored character unchanged.
- R6: Control bit 1 is interrupt enable and takes wdata bit 1 on a store to the control register. Stores never change ready. Control reads return zero in bits 31:2.
- R7: irq_o is ready AND interrupt enable. cause_ip_o carries irq_o in bit 8 (value 0x00000100) and zeros in every other bit.
- R8: A key that arrives while ready is already set overwrites the stored character, and ready stays set.
- R9: When a key arrives in the same cycle as a data-register load, the load returns the older character. After the edge, ready is set and the new character is stored.
- R10: After reset, ready, interrupt enable, the stored character and irq_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = store, 0 = load |
| bus_addr_i | input | 32 | Effective byte address |
| bus_wdata_i | input | 32 | Store data |
| bus_rdata_o | output | 32 | Load data (combinational) |
| dev_sel_o | output | 1 | Access routed to I/O device registers |
| mem_sel_o | output | 1 | Access routed to main memory |
| key_valid_i | input | 1 | One-cycle strobe: new character present |
| key_char_i | input | 8 | Character from keyboard side |
| ready_o | output | 1 | Character waiting (control bit 0) |
| irq_o | output | 1 | Keyboard interrupt request |
| cause_ip_o | output | 32 | Pending-interrupt bits for the cause register |

## Verification
Some results appear in the same cycle as the stimulus: routing, load data and the cause bits are combinational. The bench samples these 2 ns after it drives the inputs on the falling edge, before the next rising edge. Other results take one register: ready, interrupt enable, the stored character and irq_o change at the rising edge that takes the key strobe, the load or the store. The bench reads these back one full cycle later, through control and data loads and the ready_o and irq_o pins. For the R9 collision, the bench checks the load data inside the collision cycle and checks the register state in the cycle after it.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CTRL = 2'd1,
    REG_DATA = 2'd2
  } kbd_reg_e;

  localparam int unsigned CTRL_RDY_BIT = 0;
  localparam int unsigned CTRL_IE_BIT  = 1;
endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode
  import kbd_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]    IO_BASE  = 32'hFFFF_0000,
  parameter int unsigned          DATA_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              dev_sel_o,
  output logic              mem_sel_o,
  output kbd_reg_e          reg_o
);
  logic              in_io;
  logic [ADDR_W-1:0] ofs;

  assign in_io     = (addr_i >= IO_BASE);
  assign ofs       = addr_i - IO_BASE;
  assign dev_sel_o = req_i & in_io;
  assign mem_sel_o = req_i & ~in_io;

  always_comb begin
    reg_o = REG_NONE;
    if (dev_sel_o) begin
      if (ofs == ADDR_W'(0))             reg_o = REG_CTRL;
      else if (ofs == ADDR_W'(DATA_OFS)) reg_o = REG_DATA;
    end
  end

  // R1: every request goes to exactly one target
  p_one_target_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (dev_sel_o != mem_sel_o));

  // R1: no target without a request
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (!dev_sel_o && !mem_sel_o));
endmodule

// File: rtl/kbd_rx_regs.sv
module kbd_rx_regs #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_valid_i,
  input  logic [CHAR_W-1:0] key_char_i,
  input  logic              rd_data_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_ie_i,
  output logic              ready_o,
  output logic              ie_o,
  output logic [CHAR_W-1:0] char_o
);
  logic              ready_q, ie_q;
  logic [CHAR_W-1:0] char_q;

  // a fresh key wins over a concurrent read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      char_q  <= '0;
    end else if (key_valid_i) begin
      ready_q <= 1'b1;
      char_q  <= key_char_i;
    end else if (rd_data_i) begin
      ready_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ie_q <= 1'b0;
    else if (wr_ctrl_i) ie_q <= wr_ie_i;
  end

  assign ready_o = ready_q;
  assign ie_o    = ie_q;
  assign char_o  = char_q;

  // R3, R8, R9: key capture
  p_key_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i |=> (ready_q && char_q == $past(key_char_i)));

  // R4: read without key clears ready
  p_read_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !key_valid_i) |=> !ready_q);

  // R5: only a key changes the character
  p_char_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_i |=> $stable(char_q));

  // R6: software writes never touch ready
  p_ready_no_sw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_valid_i && !rd_data_i) |=> $stable(ready_q));
endmodule

// File: rtl/kbd_irq_gen.sv
module kbd_irq_gen #(
  parameter int unsigned CAUSE_W = 32,
  parameter int unsigned IRQ_BIT = 8
) (
  input  logic               ready_i,
  input  logic               ie_i,
  output logic               irq_o,
  output logic [CAUSE_W-1:0] cause_o
);
  assign irq_o = ready_i & ie_i;

  always_comb begin
    cause_o          = '0;
    cause_o[IRQ_BIT] = irq_o;
  end

  // R7: cause carries at most the one keyboard bit
  always_comb begin
    p_cause_single_r7: assert ($countones(cause_o) <= 1);
  end
endmodule

// File: rtl/kbd_mmio_port.sv
module kbd_mmio_port
  import kbd_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 32,
  parameter int unsigned       DATA_W  = 32,
  parameter int unsigned       CHAR_W  = 8,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'hFFFF_0000,
  parameter int unsigned       IRQ_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              dev_sel_o,
  output logic              mem_sel_o,
  input  logic              key_valid_i,
  input  logic [CHAR_W-1:0] key_char_i,
  output logic              ready_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] cause_ip_o
);
  localparam int unsigned DATA_OFS = DATA_W / 8;

  kbd_reg_e          reg_sel;
  logic              rd_data, wr_ctrl;
  logic              ready, ie;
  logic [CHAR_W-1:0] char_q;
  logic              unused_wdata;

  assign unused_wdata = ^{bus_wdata_i[DATA_W-1:CTRL_IE_BIT+1], bus_wdata_i[CTRL_RDY_BIT]};

  kbd_addr_decode #(
    .ADDR_W  (ADDR_W),
    .IO_BASE (IO_BASE),
    .DATA_OFS(DATA_OFS)
  ) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (bus_req_i),
    .addr_i   (bus_addr_i),
    .dev_sel_o(dev_sel_o),
    .mem_sel_o(mem_sel_o),
    .reg_o    (reg_sel)
  );

  assign rd_data = !bus_we_i && (reg_sel == REG_DATA);
  assign wr_ctrl =  bus_we_i && (reg_sel == REG_CTRL);

  kbd_rx_regs #(.CHAR_W(CHAR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_valid_i(key_valid_i),
    .key_char_i (key_char_i),
    .rd_data_i  (rd_data),
    .wr_ctrl_i  (wr_ctrl),
    .wr_ie_i    (bus_wdata_i[CTRL_IE_BIT]),
    .ready_o    (ready),
    .ie_o       (ie),
    .char_o     (char_q)
  );

  kbd_irq_gen #(.CAUSE_W(DATA_W), .IRQ_BIT(IRQ_BIT)) u_irq (
    .ready_i(ready),
    .ie_i   (ie),
    .irq_o  (irq_o),
    .cause_o(cause_ip_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (!bus_we_i) begin
      unique case (reg_sel)
        REG_CTRL: begin
          bus_rdata_o[CTRL_RDY_BIT] = ready;
          bus_rdata_o[CTRL_IE_BIT]  = ie;
        end
        REG_DATA: bus_rdata_o[CHAR_W-1:0] = char_q;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign ready_o = ready;

  // R7: consuming the character drops the request
  p_irq_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !key_valid_i) |=> !irq_o);

  // R2: unmapped I/O reads are zero
  p_unmapped_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_sel_o && reg_sel == REG_NONE) |-> (bus_rdata_o == '0));
endmodule

// File: tb/tb_kbd_mmio_port.sv
`timescale 1ns/1ps
module tb_kbd_mmio_port;
  localparam logic [31:0] A_CTRL = 32'hFFFF_0000;
  localparam logic [31:0] A_DATA = 32'hFFFF_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata, cause;
  logic        dev_sel, mem_sel, ready, irq;
  logic        kv = 1'b0;
  logic [7:0]  kc = '0;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kbd_mmio_port dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .dev_sel_o(dev_sel), .mem_sel_o(mem_sel),
    .key_valid_i(kv), .key_char_i(kc),
    .ready_o(ready), .irq_o(irq), .cause_ip_o(cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, sample mid-cycle, finish at posedge
  task automatic cyc(input logic rq, input logic w, input logic [31:0] a,
                     input logic [31:0] wd, input logic k, input logic [7:0] c);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = wd; kv = k; kc = c;
    #2;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    cyc(1'b1, 1'b0, a, '0, 1'b0, '0);
    d = rdata;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0, '0);
  endtask

  task automatic key(input logic [7:0] c);
    cyc(1'b0, 1'b0, '0, '0, 1'b1, c);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    idle();
    chk("R10 ready", {31'b0, ready}, 32'd0);
    chk("R10 irq", {31'b0, irq}, 32'd0);
    chk("R10 cause", cause, 32'd0);
    rd(A_CTRL, d); chk("R10 ctrl", d, 32'd0);
    rd(A_DATA, d); chk("R10 data", d, 32'd0);
  endtask

  task automatic t_decode();
    cyc(1'b1, 1'b0, 32'h1001_0000, '0, 1'b0, '0);
    chk("R1 low mem", {30'b0, dev_sel, mem_sel}, 32'd1);
    cyc(1'b1, 1'b0, 32'hFFFE_FFFC, '0, 1'b0, '0);
    chk("R1 just below", {30'b0, dev_sel, mem_sel}, 32'd1);
    cyc(1'b1, 1'b1, A_CTRL, '0, 1'b0, '0);
    chk("R1 base", {30'b0, dev_sel, mem_sel}, 32'd2);
    cyc(1'b1, 1'b0, 32'hFFFF_FFFC, '0, 1'b0, '0);
    chk("R1 top", {30'b0, dev_sel, mem_sel}, 32'd2);
    idle();
    chk("R1 idle", {30'b0, dev_sel, mem_sel}, 32'd0);
  endtask

  task automatic t_poll();
    logic [31:0] d;
    key(8'h41);
    idle();
    chk("R3 ready pin", {31'b0, ready}, 32'd1);
    rd(A_CTRL, d); chk("R3 ctrl", d, 32'd1);
    rd(A_DATA, d); chk("R4 data", d, 32'h41);
    idle();
    chk("R4 ready cleared", {31'b0, ready}, 32'd0);
    rd(A_CTRL, d); chk("R4 ctrl", d, 32'd0);
  endtask

  task automatic t_ro_data();
    logic [31:0] d;
    wr(A_DATA, 32'hFFFF_FFFF);
    idle();
    rd(A_DATA, d); chk("R5 data kept", d, 32'h41);
    chk("R5 ready kept", {31'b0, ready}, 32'd0);
  endtask

  task automatic t_ctrl_write();
    logic [31:0] d;
    wr(A_CTRL, 32'h0000_0003);
    idle();
    rd(A_CTRL, d); chk("R6 ie only", d, 32'd2);
    chk("R6 no irq", {31'b0, irq}, 32'd0);
    wr(32'hFFFF_0008, 32'h0);
    wr(32'hFFFF_000C, 32'hFFFF_FFFF);
    idle();
    rd(A_CTRL, d); chk("R2 other io write ignored", d, 32'd2);
    rd(32'hFFFF_0008, d); chk("R2 other io reads 0", d, 32'd0);
    rd(A_DATA, d); chk("R2 data unchanged", d, 32'h41);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    key(8'h5A);
    idle();
    chk("R7 irq", {31'b0, irq}, 32'd1);
    chk("R7 cause", cause, 32'h0000_0100);
    rd(A_CTRL, d); chk("R7 ctrl", d, 32'd3);
    wr(A_CTRL, 32'hFFFF_FFFD);
    idle();
    rd(A_CTRL, d); chk("R6 ie off ready kept", d, 32'd1);
    chk("R7 irq off", {31'b0, irq}, 32'd0);
    chk("R7 cause off", cause, 32'd0);
    wr(A_CTRL, 32'h2);
    idle();
    chk("R7 irq back", {31'b0, irq}, 32'd1);
    rd(A_DATA, d); chk("R7 data", d, 32'h5A);
    idle();
    chk("R7 irq drop on read", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_overwrite();
    logic [31:0] d;
    key(8'h31);
    key(8'h32);
    idle();
    chk("R8 ready", {31'b0, ready}, 32'd1);
    rd(A_DATA, d); chk("R8 newest", d, 32'h32);
    idle();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    key(8'h61);
    cyc(1'b1, 1'b0, A_DATA, '0, 1'b1, 8'h62);
    chk("R9 old char returned", rdata, 32'h61);
    idle();
    chk("R9 ready kept", {31'b0, ready}, 32'd1);
    chk("R9 irq kept", {31'b0, irq}, 32'd1);
    rd(A_DATA, d); chk("R9 new char", d, 32'h62);
    idle();
    chk("R9 then cleared", {31'b0, ready}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_poll();
    t_ro_data();
    t_ctrl_write();
    t_irq();
    t_overwrite();
    t_collide();
    idle();
    finish_run();
  end
endmodule